// File: doc/BRIEF.md
# Progressive-to-Interlaced Field Converter

This block sits in a streaming video pipeline and turns every progressive frame it receives into a single interlaced field. It does this by passing on only the even-indexed lines (an F0 field) or only the odd-indexed lines (an F1 field) of that frame. Pixels arrive one per beat, with a valid/ready handshake, a start-of-frame marker and an end-of-line marker. A descriptor with the frame's width, height and 4-bit interlace code goes with the frame and is captured on its first beat. The output uses the same stream format and carries a descriptor that matches the field actually produced.

Frames that are already fields go through untouched. Frames that were made by deinterlacing can be returned to their original polarity. Plain progressive frames alternate between F0 and F1, and the alternation restarts whenever the geometry or the code changes. A small register set, written through simple strobes, holds the enable, the polarity used after a restart and the history switch. It also holds a lite mode, in which the descriptor comes from registers instead of from the stream. Register settings take effect only at a frame boundary.

Top module: `field_interlacer`

## Requirements
- R1: A progressive frame in interlacing mode produces exactly one field. An F0 field passes every beat of lines 0, 2, 4, … and an F1 field passes every beat of lines 1, 3, 5, …. Lines are counted from 0 at the start-of-frame beat and advance on each accepted end-of-line beat.
- R2: A frame whose interlace code is 8 to 15 is forwarded beat for beat. Its output descriptor equals its input descriptor (codes 8–11 are F0 fields, 12–15 are F1 fields).
- R3: Successive interlaced progressive frames with the same descriptor alternate F0, F1, F0, … unless history honouring forces a polarity.
- R4: The alternation restarts on the first frame after reset, and on any frame whose width, height or code differs from the previous frame's. The restart frame is F1 when the first-field bit is 1 and F0 otherwise.
- R5: With history honouring on, codes 0 and 4 produce F0 and codes 1 and 5 produce F1. With it off, these codes follow R3/R4. Codes 2, 3, 6 and 7 always follow R3/R4.
- R6: With the enable bit at 0, progressive frames pass through unaltered with an unchanged descriptor. Such frames do not advance the alternation.
- R7: The output descriptor keeps the width. It reports height ceil(H/2) and code 10 for F0, and height floor(H/2) and code 14 for F1.
- R8: Beats of dropped lines are accepted with inReady high even while outReady is low, and produce no output beat. The first kept beat of a frame carries outSof, and every kept beat carries its input end-of-line marker.
- R9: In lite mode the descriptor comes from the width, height and code registers. Any write to one of these registers makes the next frame restart the alternation, even if the value is unchanged.
- R10: Register values are sampled on the start-of-frame beat. A write during a frame affects only later frames.
- R11: Registers are written with regWrite and the address regAddr. Address 0 holds bit0 enable, bit1 first-field F1, bit2 history honouring and bit3 lite mode. Addresses 1, 2 and 3 hold the lite width, height and code. After reset: enable 1, all other bits 0, and outValid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | DIM_W | Register write data |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted |
| inData | input | PIX_W | Input pixel |
| inSof | input | 1 | First beat of frame |
| inEol | input | 1 | Last beat of line |
| inWidth | input | DIM_W | Frame width in pixels |
| inHeight | input | DIM_W | Frame height in lines |
| inCode | input | 4 | Interlace code |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream ready |
| outData | output | PIX_W | Output pixel |
| outSof | output | 1 | First beat of output field |
| outEol | output | 1 | Last beat of output line |
| outWidth | output | DIM_W | Output width |
| outHeight | output | DIM_W | Output height |
| outCode | output | 4 | Output interlace code |

## Verification
A wrong line-parity register shows up on the first output line of a frame: the lines appear with the wrong index or the wrong beat count, and the start marker falls on the wrong beat. A wrong previous-descriptor or last-polarity state does not show until the next start-of-frame beat. There it gives the wrong polarity, visible at once on outCode and outHeight. Each frame in the table is therefore preceded by a frame chosen to set up that state, so that a fault appears at a known frame.

// File: rtl/ilc_pkg.sv
package ilc_pkg;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_F0   = 2'd1,
    MODE_F1   = 2'd2
  } fieldMode_e;

  // Packed so that bits [3:0] of a control write map straight onto it
  typedef struct packed {
    logic lite;
    logic honour;
    logic firstF1;
    logic enable;
  } cfg_t;

  // Control to datapath
  typedef struct packed {
    fieldMode_e mode;
    logic       sofNow;
  } ctrlToDp_t;

  // Datapath to control
  typedef struct packed {
    logic sofAccept;
  } dpToCtrl_t;

  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_F0_OUT = 4'd10;
  localparam logic [CODE_W-1:0] CODE_F1_OUT = 4'd14;

endpackage

// File: rtl/ilc_regs.sv
module ilc_regs
  import ilc_pkg::*;
#(
  parameter int DIM_W  = 12,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DIM_W-1:0]  regWdata,
  output cfg_t              cfg,
  output logic [DIM_W-1:0]  liteWidth,
  output logic [DIM_W-1:0]  liteHeight,
  output logic [CODE_W-1:0] liteCode,
  output logic              descWrite
);

  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_WID  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_HGT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_CODE = ADDR_W'(3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg        <= '{lite: 1'b0, honour: 1'b0, firstF1: 1'b0, enable: 1'b1};
      liteWidth  <= '0;
      liteHeight <= '0;
      liteCode   <= '0;
    end else if (regWrite) begin
      case (regAddr)
        ADDR_CTRL: cfg        <= cfg_t'(regWdata[3:0]);
        ADDR_WID:  liteWidth  <= regWdata;
        ADDR_HGT:  liteHeight <= regWdata;
        ADDR_CODE: liteCode   <= regWdata[CODE_W-1:0];
        default:   ;
      endcase
    end
  end

  assign descWrite = regWrite && (regAddr != ADDR_CTRL);

endmodule

// File: rtl/ilc_ctrl.sv
module ilc_ctrl
  import ilc_pkg::*;
#(
  parameter int DIM_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  logic [DIM_W-1:0]  liteWidth,
  input  logic [DIM_W-1:0]  liteHeight,
  input  logic [CODE_W-1:0] liteCode,
  input  logic              descWrite,
  input  logic              inValid,
  input  logic              inSof,
  input  logic [DIM_W-1:0]  inWidth,
  input  logic [DIM_W-1:0]  inHeight,
  input  logic [CODE_W-1:0] inCode,
  input  dpToCtrl_t         dpStat,
  output ctrlToDp_t         ctrl,
  output logic [DIM_W-1:0]  outWidth,
  output logic [DIM_W-1:0]  outHeight,
  output logic [CODE_W-1:0] outCode
);

  // Effective descriptor: stream or lite registers
  logic [DIM_W-1:0]  effW, effH;
  logic [CODE_W-1:0] effCode;
  assign effW    = cfg.lite ? liteWidth  : inWidth;
  assign effH    = cfg.lite ? liteHeight : inHeight;
  assign effCode = cfg.lite ? liteCode   : inCode;

  // Sequence state
  logic              prevValid;
  logic [DIM_W-1:0]  prevW, prevH;
  logic [CODE_W-1:0] prevCode;
  logic              lastF1;
  logic              descDirty;

  // Frame state held for the rest of a frame
  fieldMode_e        heldMode;
  logic [DIM_W-1:0]  heldW, heldH;
  logic [CODE_W-1:0] heldCode;

  logic isField, hist0, hist1, restart, seqF1;
  fieldMode_e newMode;
  logic [DIM_W:0]    hPlus;
  logic [DIM_W-1:0]  newH;
  logic [CODE_W-1:0] newCode;

  assign isField = effCode[3];
  assign hist0   = !effCode[3] && (effCode[1:0] == 2'd0);
  assign hist1   = !effCode[3] && (effCode[1:0] == 2'd1);
  assign restart = !prevValid || descDirty || (effW != prevW) ||
                   (effH != prevH) || (effCode != prevCode);
  assign seqF1   = restart ? cfg.firstF1 : !lastF1;

  always_comb begin
    if (isField || !cfg.enable)   newMode = MODE_PASS;
    else if (cfg.honour && hist0) newMode = MODE_F0;
    else if (cfg.honour && hist1) newMode = MODE_F1;
    else if (seqF1)               newMode = MODE_F1;
    else                          newMode = MODE_F0;
  end

  assign hPlus = {1'b0, effH} + {{DIM_W{1'b0}}, 1'b1};

  always_comb begin
    case (newMode)
      MODE_F0: begin newH = hPlus[DIM_W:1]; newCode = CODE_F0_OUT; end
      MODE_F1: begin newH = effH >> 1;      newCode = CODE_F1_OUT; end
      default: begin newH = effH;           newCode = effCode;     end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevW     <= '0;
      prevH     <= '0;
      prevCode  <= '0;
      lastF1    <= 1'b0;
      heldMode  <= MODE_PASS;
      heldW     <= '0;
      heldH     <= '0;
      heldCode  <= '0;
    end else if (dpStat.sofAccept) begin
      prevValid <= 1'b1;
      prevW     <= effW;
      prevH     <= effH;
      prevCode  <= effCode;
      if (newMode != MODE_PASS) lastF1 <= (newMode == MODE_F1);
      heldMode  <= newMode;
      heldW     <= effW;
      heldH     <= newH;
      heldCode  <= newCode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       descDirty <= 1'b0;
    else if (descWrite && cfg.lite)  descDirty <= 1'b1;
    else if (dpStat.sofAccept)       descDirty <= 1'b0;
  end

  assign ctrl.sofNow = inValid && inSof;
  assign ctrl.mode   = ctrl.sofNow ? newMode : heldMode;
  assign outWidth    = ctrl.sofNow ? effW    : heldW;
  assign outHeight   = ctrl.sofNow ? newH    : heldH;
  assign outCode     = ctrl.sofNow ? newCode : heldCode;

endmodule

// File: rtl/ilc_datapath.sv
module ilc_datapath
  import ilc_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlToDp_t        ctrl,
  input  logic             inValid,
  output logic             inReady,
  input  logic [PIX_W-1:0] inData,
  input  logic             inSof,
  input  logic             inEol,
  output logic             outValid,
  input  logic             outReady,
  output logic [PIX_W-1:0] outData,
  output logic             outSof,
  output logic             outEol,
  output dpToCtrl_t        dpStat
);

  logic lineOdd, pendSof;
  logic curOdd, keep, accept, outFire;

  assign curOdd   = ctrl.sofNow ? 1'b0 : lineOdd;
  assign keep     = (ctrl.mode == MODE_PASS) ||
                    ((ctrl.mode == MODE_F1) == curOdd);
  assign outValid = inValid && keep;
  assign inReady  = keep ? outReady : 1'b1;
  assign outData  = inData;
  assign outEol   = inEol;
  assign outSof   = inSof || pendSof;

  assign accept           = inValid && inReady;
  assign outFire          = outValid && outReady;
  assign dpStat.sofAccept = accept && inSof;

  always_ff @(posedge clk) begin
    if (!rstN)                lineOdd <= 1'b0;
    else if (accept && inSof) lineOdd <= inEol;
    else if (accept && inEol) lineOdd <= !lineOdd;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  pendSof <= 1'b0;
    else if (outFire)           pendSof <= 1'b0;
    else if (dpStat.sofAccept)  pendSof <= 1'b1;
  end

endmodule

// File: rtl/field_interlacer.sv
module field_interlacer
  import ilc_pkg::*;
#(
  parameter int PIX_W  = 24,
  parameter int DIM_W  = 12,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DIM_W-1:0]  regWdata,
  input  logic              inValid,
  output logic              inReady,
  input  logic [PIX_W-1:0]  inData,
  input  logic              inSof,
  input  logic              inEol,
  input  logic [DIM_W-1:0]  inWidth,
  input  logic [DIM_W-1:0]  inHeight,
  input  logic [3:0]        inCode,
  output logic              outValid,
  input  logic              outReady,
  output logic [PIX_W-1:0]  outData,
  output logic              outSof,
  output logic              outEol,
  output logic [DIM_W-1:0]  outWidth,
  output logic [DIM_W-1:0]  outHeight,
  output logic [3:0]        outCode
);

  cfg_t              cfg;
  logic [DIM_W-1:0]  liteWidth, liteHeight;
  logic [CODE_W-1:0] liteCode;
  logic              descWrite;
  ctrlToDp_t         ctrl;
  dpToCtrl_t         dpStat;

  ilc_regs #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .cfg(cfg), .liteWidth(liteWidth),
    .liteHeight(liteHeight), .liteCode(liteCode), .descWrite(descWrite)
  );

  ilc_ctrl #(.DIM_W(DIM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .liteWidth(liteWidth),
    .liteHeight(liteHeight), .liteCode(liteCode), .descWrite(descWrite),
    .inValid(inValid), .inSof(inSof), .inWidth(inWidth),
    .inHeight(inHeight), .inCode(inCode), .dpStat(dpStat), .ctrl(ctrl),
    .outWidth(outWidth), .outHeight(outHeight), .outCode(outCode)
  );

  ilc_datapath #(.PIX_W(PIX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inValid(inValid),
    .inReady(inReady), .inData(inData), .inSof(inSof), .inEol(inEol),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outSof(outSof), .outEol(outEol), .dpStat(dpStat)
  );

endmodule

// File: rtl/ilc_checker.sv
module ilc_checker #(
  parameter int PIX_W = 24,
  parameter int DIM_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             inSof,
  input logic             outValid,
  input logic             outSof,
  input logic [3:0]       outCode,
  input logic [PIX_W-1:0] outData,
  input logic [DIM_W-1:0] outHeight
);

  // R8
  no_orphan_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inValid);

  // R8
  drop_consumed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !outValid) |-> inReady);

  // R8
  regen_sof_f1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSof && !inSof) |-> (outCode == 4'd14));

  // R1
  f0_sof_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSof && (outCode == 4'd10)) |-> inSof);

  // R11
  idle_after_reset_chk: assert property (@(posedge clk)
    $rose(rstN) |-> !outValid || inValid);

endmodule

bind field_interlacer ilc_checker #(.PIX_W(PIX_W), .DIM_W(DIM_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inSof(inSof), .outValid(outValid), .outSof(outSof), .outCode(outCode),
  .outData(outData), .outHeight(outHeight)
);

// File: tb/test_field_interlacer.sv
`timescale 1ns/1ps
module test_field_interlacer;

  localparam int PIX_W = 24;
  localparam int DIM_W = 12;

  logic clk = 0, rstN = 0;
  logic regWrite = 0;
  logic [1:0] regAddr = 0;
  logic [DIM_W-1:0] regWdata = 0;
  logic inValid = 0, inSof = 0, inEol = 0, inReady;
  logic [PIX_W-1:0] inData = 0;
  logic [DIM_W-1:0] inWidth = 0, inHeight = 0;
  logic [3:0] inCode = 0;
  logic outValid, outReady = 1, outSof, outEol;
  logic [PIX_W-1:0] outData;
  logic [DIM_W-1:0] outWidth, outHeight;
  logic [3:0] outCode;

  int total = 0, bad = 0, cyc = 0, curCtrl = 1;

  always #4 clk = ~clk;

  field_interlacer i_field_interlacer (.*);

  // Watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic writeReg(input int addr, input int data);
    @(negedge clk);
    regWrite = 1; regAddr = addr[1:0]; regWdata = data[DIM_W-1:0];
    @(negedge clk);
    regWrite = 0;
  endtask

  // mode: 0 pass, 1 F0, 2 F1
  task automatic sendFrame(input int w, input int h, input int dw, input int dh,
                           input int dc, input int mode, input bit stall,
                           input int midCtrl, input string tag);
    int beats = 0, sofs = 0, badLine = 0, badDrop = 0, badEol = 0;
    int firstSofOk = 1, gotW = -1, gotH = -1, gotC = -1;
    int expBeats, expH, expC;
    expBeats = (mode == 1) ? w * ((h + 1) / 2) : (mode == 2) ? w * (h / 2) : w * h;
    expH = (mode == 1) ? (h + 1) / 2 : (mode == 2) ? h / 2 : h;
    expC = (mode == 1) ? 10 : (mode == 2) ? 14 : dc;
    for (int l = 0; l < h; l++) begin
      for (int c = 0; c < w; c++) begin
        bit done = 0;
        bit drop;
        drop = (mode == 1) ? (l % 2 == 1) : (mode == 2) ? (l % 2 == 0) : 1'b0;
        @(negedge clk);
        inValid = 1; inData = {8'h00, l[7:0], c[7:0]};
        inSof = (l == 0 && c == 0); inEol = (c == w - 1);
        inWidth = dw[DIM_W-1:0]; inHeight = dh[DIM_W-1:0]; inCode = dc[3:0];
        if (midCtrl >= 0 && l == 0 && c == 1) begin
          regWrite = 1; regAddr = 0; regWdata = midCtrl[DIM_W-1:0];
        end else regWrite = 0;
        while (!done) begin
          outReady = !(stall && (cyc % 3 == 0));
          #1;
          if (drop && (!inReady || outValid)) badDrop++;
          if (outValid && outReady) begin
            beats++;
            if (beats == 1) begin
              if (!outSof) firstSofOk = 0;
              gotW = outWidth; gotH = outHeight; gotC = outCode;
            end
            if (outSof) sofs++;
            if (mode == 1 && outData[8]) badLine++;
            if (mode == 2 && !outData[8]) badLine++;
            if (outEol != (c == w - 1)) badEol++;
          end
          done = inReady;
          @(posedge clk);
          if (!done) @(negedge clk);
        end
      end
    end
    @(negedge clk);
    inValid = 0; inSof = 0; inEol = 0; regWrite = 0; outReady = 1;
    // R1 beat count equals kept lines; tag names the sequencing requirement
    check(beats == expBeats, tag, "beat count", beats, expBeats);
    check(badLine == 0, "R1", "lines of wrong parity", badLine, 0);
    check(badDrop == 0, "R8", "dropped-line handshake errors", badDrop, 0);
    check(sofs == (expBeats > 0 ? 1 : 0) && firstSofOk == 1, "R8", "sof count", sofs, 1);
    check(badEol == 0, "R8", "eol mismatches", badEol, 0);
    if (expBeats > 0) begin
      check(gotW == w, (mode == 0) ? "R2" : "R7", "out width", gotW, w);
      check(gotH == expH, (mode == 0) ? "R2" : "R7", "out height", gotH, expH);
      check(gotC == expC, (mode == 0) ? "R2" : "R7", "out code", gotC, expC);
    end
  endtask

  typedef struct packed {
    logic [7:0] w, h, code, ctrl, mode, req;
  } vec_t;

  // ctrl: bit0 enable, bit1 first F1, bit2 honour; mode 0 pass/1 F0/2 F1
  localparam vec_t VECS[20] = '{
    '{8'd4, 8'd4, 8'd2,  8'd1, 8'd1, 8'd4},  // R4 first after reset
    '{8'd4, 8'd4, 8'd2,  8'd1, 8'd2, 8'd3},  // R3
    '{8'd4, 8'd4, 8'd2,  8'd1, 8'd1, 8'd3},
    '{8'd4, 8'd5, 8'd2,  8'd1, 8'd1, 8'd4},  // height change
    '{8'd4, 8'd5, 8'd2,  8'd1, 8'd2, 8'd3},
    '{8'd3, 8'd5, 8'd3,  8'd1, 8'd1, 8'd4},  // width and code change
    '{8'd3, 8'd5, 8'd9,  8'd1, 8'd0, 8'd2},  // R2 field passes
    '{8'd3, 8'd5, 8'd3,  8'd1, 8'd1, 8'd4},
    '{8'd3, 8'd5, 8'd3,  8'd3, 8'd2, 8'd3},  // first-field bit no restart
    '{8'd3, 8'd5, 8'd6,  8'd3, 8'd2, 8'd4},  // restart to F1
    '{8'd3, 8'd5, 8'd6,  8'd3, 8'd1, 8'd3},
    '{8'd3, 8'd5, 8'd0,  8'd7, 8'd1, 8'd5},  // R5 honour
    '{8'd3, 8'd5, 8'd0,  8'd7, 8'd1, 8'd5},
    '{8'd3, 8'd5, 8'd1,  8'd7, 8'd2, 8'd5},
    '{8'd3, 8'd5, 8'd1,  8'd3, 8'd1, 8'd5},  // honour off: alternate
    '{8'd3, 8'd5, 8'd1,  8'd2, 8'd0, 8'd6},  // R6 disabled
    '{8'd3, 8'd5, 8'd1,  8'd3, 8'd2, 8'd6},  // sequence untouched by pass
    '{8'd3, 8'd5, 8'd13, 8'd3, 8'd0, 8'd2},
    '{8'd4, 8'd1, 8'd2,  8'd3, 8'd2, 8'd7},  // F1 of one line: empty
    '{8'd4, 8'd1, 8'd2,  8'd3, 8'd1, 8'd7}
  };

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    // R11 reset state: idle output
    check(outValid == 0, "R11", "outValid after reset", outValid, 0);

    for (int i = 0; i < 20; i++) begin
      vec_t v;
      v = VECS[i];
      if (int'(v.ctrl) != curCtrl) begin
        writeReg(0, v.ctrl);
        curCtrl = v.ctrl;
      end
      sendFrame(v.w, v.h, v.w, v.h, v.code, v.mode, i[0], -1,
                $sformatf("R%0d", v.req));
    end

    // R10: restart to F1, disable written mid-frame must not split it
    writeReg(0, 3);
    sendFrame(4, 4, 4, 4, 2, 2, 1'b1, 2, "R10");
    sendFrame(4, 4, 4, 4, 2, 0, 1'b0, -1, "R10");
    writeReg(0, 3);
    // R6: disabled frame left last polarity at F1
    sendFrame(4, 4, 4, 4, 2, 1, 1'b0, -1, "R6");

    // R9 lite mode: stream descriptor ignored, registers used
    writeReg(1, 2); writeReg(2, 3); writeReg(3, 2); writeReg(0, 9);
    sendFrame(2, 3, 7, 6, 9, 1, 1'b0, -1, "R9");
    sendFrame(2, 3, 7, 6, 9, 2, 1'b1, -1, "R9");
    writeReg(2, 3);   // same value still restarts
    sendFrame(2, 3, 7, 6, 9, 1, 1'b0, -1, "R9");
    sendFrame(2, 3, 7, 6, 9, 2, 1'b0, -1, "R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule